// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Port

This block is the processor-facing half of an interrupt controller. The distributor hands it a single candidate: the best pending interrupt for this processor, with its ID, an 8-bit priority and, for software-generated interrupts, the number of the processor that raised it. The port decides whether that candidate may be signalled, drives the processor's interrupt request line, and turns register accesses into the claim and retire events the distributor needs.

Software claims an interrupt by reading the acknowledge register. That read returns the ID and moves the interrupt from pending to active, which is reported to the distributor as a one-cycle pulse carrying the ID. Software retires the interrupt by writing its ID to the end-of-interrupt register, which produces a matching pulse. The port keeps its own small table of active IDs. An ID in that table is never signalled or claimed again until it is retired. An enable bit and a priority threshold decide which candidates reach the processor.

All processors see this register set at the same addresses. Each access carries the number of the requesting processor, and an instance answers only accesses carrying its own number. Reads have one cycle of latency.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset the enable bit and the priority threshold are zero, the active table is empty, irq is low, and both pulse outputs are low.
- R2: irq is high exactly when the enable bit (bit 0 at offset 0x00) is set, cand_valid is high, cand_prio is strictly less than the threshold (bits 7:0 at offset 0x04), cand_id is not in the active table, and the table has a free entry.
- R3: A read of offset 0x0C while irq is high returns cand_id in rdata bits 9:0 one cycle later. In that same cycle ack_pulse is high for one cycle and ack_id equals the claimed ID.
- R4: If the claimed ID is below 16 (software-generated), rdata bits 12:10 carry cand_src. For any other ID those bits are zero.
- R5: A read of offset 0x0C while irq is low returns 1023, raises no ack_pulse and changes no state.
- R6: A claimed ID enters the active table. It is neither signalled nor claimable again until it is retired.
- R7: A write to offset 0x10 whose bits 9:0 name an active ID removes that ID from the table. One cycle later eoi_pulse is high with eoi_id equal to that ID.
- R8: A write to offset 0x10 naming an ID that is not active is ignored: no pulse, and the table is unchanged.
- R9: An access whose req_cpu differs from the CPU_INDEX parameter has no effect. A read of that kind returns zero.
- R10: The enable and threshold registers read back their stored values with all other bits zero. Unmapped offsets read as zero.
- R11: The active table holds ACT_DEPTH IDs. While it is full, nothing is signalled and acknowledge reads return 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_cpu | input | 3 | Number of the processor making the register access |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| cand_valid | input | 1 | Distributor presents a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower value is more urgent |
| cand_src | input | 3 | Requesting processor for software interrupts |
| irq | output | 1 | Interrupt request to the processor |
| ack_pulse | output | 1 | One-cycle claim notice to the distributor |
| ack_id | output | 10 | ID being claimed |
| eoi_pulse | output | 1 | One-cycle retire notice to the distributor |
| eoi_id | output | 10 | ID being retired |

## Verification
The bench attacks the priority comparison at equality. A port that used less-or-equal would signal a candidate whose priority equals the threshold. It repeats a claim of an ID that is already active while the distributor still presents it; a design without the active table would hand out the same ID twice. It sends retire writes naming IDs that are not active, then shows that the real active ID stays blocked. It fills the table and shows that new candidates are held off. It also sends accesses tagged with another processor's number, which a port without the alias check would let change its enable bit or steal a claim.

// File: rtl/irqcpu_pkg.sv
package irqcpu_pkg;
  localparam int ID_W     = 10;
  localparam int PRIO_W   = 8;
  localparam int SRC_W    = 3;
  localparam int SGI_LAST = 15;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  // word indices of the register map (byte address / 4)
  localparam logic [2:0] W_CTRL  = 3'd0;
  localparam logic [2:0] W_PMASK = 3'd1;
  localparam logic [2:0] W_ACK   = 3'd3;
  localparam logic [2:0] W_EOI   = 3'd4;

  typedef logic [ID_W-1:0]   irq_id_t;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/cpuif_regs.sv
module cpuif_regs
  import irqcpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit,
  input  logic              wr_hit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ack_word,
  output logic              ctl_en,
  output prio_t             pmask,
  output logic              ack_rd,
  output logic              eoi_wr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              sel_ctrl, sel_pmask, sel_ack, sel_eoi;
  logic              ctl_en_d, ctl_we;
  prio_t             pmask_d;
  logic              pmask_we;
  logic [DATA_W-1:0] rd_mux, rdata_d;

  assign widx      = addr[ADDR_W-1:2];
  assign sel_ctrl  = (widx == WIDX_W'(W_CTRL));
  assign sel_pmask = (widx == WIDX_W'(W_PMASK));
  assign sel_ack   = (widx == WIDX_W'(W_ACK));
  assign sel_eoi   = (widx == WIDX_W'(W_EOI));

  assign ack_rd = rd_hit && sel_ack;
  assign eoi_wr = wr_hit && sel_eoi;

  always_comb begin
    ctl_we   = wr_hit && sel_ctrl;
    pmask_we = wr_hit && sel_pmask;
    ctl_en_d = wdata[0];
    pmask_d  = wdata[PRIO_W-1:0];
    rd_mux   = '0;
    if (sel_ctrl)       rd_mux = DATA_W'(ctl_en);
    else if (sel_pmask) rd_mux = DATA_W'(pmask);
    else if (sel_ack)   rd_mux = ack_word;
    rdata_d  = rd_hit ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0;
      pmask  <= '0;
      rdata  <= '0;
    end else begin
      if (ctl_we)   ctl_en <= ctl_en_d;
      if (pmask_we) pmask  <= pmask_d;
      rdata <= rdata_d;
    end
  end

  AST_PMASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !pmask_we |=> $stable(pmask)) else $error("threshold changed without write"); // R10
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active #(
  parameter int DEPTH = 4,
  parameter int ID_W  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_en,
  input  logic [ID_W-1:0] ins_id,
  input  logic            rem_en,
  input  logic [ID_W-1:0] rem_id,
  input  logic [ID_W-1:0] probe_id,
  output logic            probe_hit,
  output logic            rem_hit,
  output logic            full
);
  logic [DEPTH-1:0] valid_q, valid_d;
  logic [DEPTH-1:0] probe_m, rem_m, slot_oh;
  logic [ID_W-1:0]  id_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    assign probe_m[gi] = valid_q[gi] && (id_q[gi] == probe_id);
    assign rem_m[gi]   = valid_q[gi] && (id_q[gi] == rem_id);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    id_q[gi] <= '0;
      else if (ins_en && slot_oh[gi]) id_q[gi] <= ins_id;
    end
  end

  always_comb begin : p_slot
    logic found;
    found   = 1'b0;
    slot_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_q[i] && !found) begin
        slot_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (rem_en) valid_d = valid_d & ~rem_m;
    if (ins_en) valid_d = valid_d | slot_oh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign probe_hit = |probe_m;
  assign rem_hit   = |rem_m;
  assign full      = &valid_q;

  AST_NO_INSERT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !full) else $error("insert into full table"); // R11
  AST_STRAY_EOI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_en && !rem_hit && !ins_en) |=> $stable(valid_q)) else $error("stray retire changed table"); // R8
  AST_RETIRE_FREES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_en && rem_hit && !ins_en) |=> ($countones(valid_q) + 1 == $countones($past(valid_q))))
    else $error("retire did not free exactly one entry"); // R7
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irqcpu_pkg::*;
#(
  parameter int CPU_INDEX = 2,
  parameter int ACT_DEPTH = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SRC_W-1:0]    req_cpu,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic                cand_valid,
  input  logic [ID_W-1:0]     cand_id,
  input  logic [PRIO_W-1:0]   cand_prio,
  input  logic [SRC_W-1:0]    cand_src,
  output logic                irq,
  output logic                ack_pulse,
  output logic [ID_W-1:0]     ack_id,
  output logic                eoi_pulse,
  output logic [ID_W-1:0]     eoi_id
);
  localparam int ACKW = ID_W + SRC_W;

  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic              bus_hit, rd_hit, wr_hit;
  logic              ctl_en;
  prio_t             pmask;
  logic              ack_rd, eoi_wr;
  logic              blocked, rem_hit, tbl_full;
  logic              cand_ok, irq_w, ack_take, eoi_take;
  logic [SRC_W-1:0]  src_field;
  logic [ACKW-1:0]   ack_val;
  logic [DATA_W-1:0] ack_word;
  irq_id_t           eoi_req_id;
  logic              ack_pulse_d, eoi_pulse_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign bus_hit    = (req_cpu == SRC_W'(CPU_INDEX));
  assign rd_hit     = rd_en && bus_hit;
  assign wr_hit     = wr_en && bus_hit;
  assign eoi_req_id = wdata[ID_W-1:0];

  cpuif_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .rd_hit  (rd_hit),
    .wr_hit  (wr_hit),
    .addr    (addr),
    .wdata   (wdata),
    .ack_word(ack_word),
    .ctl_en  (ctl_en),
    .pmask   (pmask),
    .ack_rd  (ack_rd),
    .eoi_wr  (eoi_wr),
    .rdata   (rdata)
  );

  cpuif_active #(.DEPTH(ACT_DEPTH), .ID_W(ID_W)) u_active (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ins_en   (ack_take),
    .ins_id   (cand_id),
    .rem_en   (eoi_wr),
    .rem_id   (eoi_req_id),
    .probe_id (cand_id),
    .probe_hit(blocked),
    .rem_hit  (rem_hit),
    .full     (tbl_full)
  );

  always_comb begin
    cand_ok   = cand_valid && (cand_prio < pmask) && !blocked && !tbl_full;
    irq_w     = ctl_en && cand_ok;
    ack_take  = ack_rd && irq_w;
    eoi_take  = eoi_wr && rem_hit;
    src_field = (cand_id <= ID_W'(SGI_LAST)) ? cand_src : '0;
    ack_val   = irq_w ? {src_field, cand_id} : {{SRC_W{1'b0}}, SPURIOUS_ID};
    ack_word  = DATA_W'(ack_val);
    ack_pulse_d = ack_take;
    eoi_pulse_d = eoi_take;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ack_pulse <= 1'b0;
      eoi_pulse <= 1'b0;
      ack_id    <= '0;
      eoi_id    <= '0;
    end else begin
      ack_pulse <= ack_pulse_d;
      eoi_pulse <= eoi_pulse_d;
      if (ack_take) ack_id <= cand_id;
      if (eoi_take) eoi_id <= eoi_req_id;
    end
  end

  assign irq = irq_w;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> ctl_en) else $error("irq while disabled"); // R2
  AST_IRQ_UNDER_MASK: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> (cand_prio < pmask)) else $error("irq at or above threshold"); // R2
  AST_CLAIM_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_core_n)
    ack_take |-> !blocked) else $error("claim of active id"); // R6
  AST_SPURIOUS_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (ack_rd && !irq) |=> !ack_pulse) else $error("pulse on spurious read"); // R5
  AST_FOREIGN_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!bus_hit) |=> (!ack_pulse && !eoi_pulse && $stable(ctl_en))) else $error("foreign access acted"); // R9
endmodule

// File: tb/tb_irq_cpu_port.sv
`timescale 1ns/1ps
module tb_irq_cpu_port;
  localparam int CPU = 2;
  localparam logic [1:0] OP_NONE = 2'd0;
  localparam logic [1:0] OP_ACK  = 2'd1;
  localparam logic [1:0] OP_EOI  = 2'd2;
  localparam logic [7:0] A_CTRL = 8'h00, A_PMASK = 8'h04, A_ACK = 8'h0C, A_EOI = 8'h10;

  typedef struct packed {
    logic       en;
    logic [7:0] mask;
    logic       cv;
    logic [9:0] cid;
    logic [7:0] cp;
    logic [2:0] cs;
    logic [1:0] op;
    logic [9:0] wid;
    logic       xirq;
    logic       xpls;
    logic [31:0] xrd;
    logic [3:0] req;
  } vec_t;

  // stimulus then expectation; state (active table) carries from row to row
  localparam vec_t VECS [20] = '{
    '{1'b0, 8'hF0, 1'b1, 10'd40,   8'hA0, 3'd0, OP_NONE, 10'd0,  1'b0, 1'b0, 32'd0,     4'd2},  // R2 disabled
    '{1'b1, 8'hF0, 1'b1, 10'd40,   8'hA0, 3'd0, OP_ACK,  10'd0,  1'b1, 1'b1, 32'd40,    4'd3},  // R3 claim
    '{1'b1, 8'hF0, 1'b1, 10'd40,   8'hA0, 3'd0, OP_ACK,  10'd0,  1'b0, 1'b0, 32'd1023,  4'd6},  // R6 active blocked
    '{1'b1, 8'hF0, 1'b1, 10'd41,   8'hF0, 3'd0, OP_ACK,  10'd0,  1'b0, 1'b0, 32'd1023,  4'd2},  // R2 equal prio
    '{1'b1, 8'hF0, 1'b1, 10'd41,   8'hEF, 3'd0, OP_ACK,  10'd0,  1'b1, 1'b1, 32'd41,    4'd3},
    '{1'b1, 8'hF0, 1'b1, 10'd40,   8'hA0, 3'd0, OP_EOI,  10'd99, 1'b0, 1'b0, 32'd0,     4'd8},  // R8 stray retire
    '{1'b1, 8'hF0, 1'b1, 10'd40,   8'hA0, 3'd0, OP_EOI,  10'd40, 1'b0, 1'b1, 32'd0,     4'd7},  // R7 retire
    '{1'b1, 8'hF0, 1'b1, 10'd40,   8'hA0, 3'd0, OP_ACK,  10'd0,  1'b1, 1'b1, 32'd40,    4'd7},
    '{1'b1, 8'hF0, 1'b1, 10'd5,    8'h10, 3'd3, OP_ACK,  10'd0,  1'b1, 1'b1, 32'hC05,   4'd4},  // R4 sgi source
    '{1'b1, 8'hF0, 1'b1, 10'd20,   8'h10, 3'd5, OP_ACK,  10'd0,  1'b1, 1'b1, 32'd20,    4'd4},
    '{1'b1, 8'hF0, 1'b1, 10'd50,   8'h00, 3'd0, OP_ACK,  10'd0,  1'b0, 1'b0, 32'd1023,  4'd11}, // R11 full
    '{1'b1, 8'hF0, 1'b1, 10'd50,   8'h00, 3'd0, OP_EOI,  10'd41, 1'b0, 1'b1, 32'd0,     4'd7},
    '{1'b1, 8'hF0, 1'b1, 10'd50,   8'h00, 3'd0, OP_ACK,  10'd0,  1'b1, 1'b1, 32'd50,    4'd11},
    '{1'b1, 8'hF0, 1'b0, 10'd50,   8'h00, 3'd0, OP_EOI,  10'd50, 1'b0, 1'b1, 32'd0,     4'd7},
    '{1'b1, 8'hF0, 1'b0, 10'd50,   8'h00, 3'd0, OP_ACK,  10'd0,  1'b0, 1'b0, 32'd1023,  4'd5},  // R5 spurious
    '{1'b1, 8'hF0, 1'b1, 10'd1020, 8'h00, 3'd0, OP_ACK,  10'd0,  1'b1, 1'b1, 32'd1020,  4'd3},
    '{1'b0, 8'hF0, 1'b1, 10'd99,   8'h00, 3'd0, OP_EOI,  10'd5,  1'b0, 1'b1, 32'd0,     4'd7},
    '{1'b0, 8'hF0, 1'b1, 10'd99,   8'h00, 3'd0, OP_ACK,  10'd0,  1'b0, 1'b0, 32'd1023,  4'd2},
    '{1'b1, 8'h00, 1'b1, 10'd99,   8'h00, 3'd0, OP_ACK,  10'd0,  1'b0, 1'b0, 32'd1023,  4'd2},
    '{1'b1, 8'hFF, 1'b1, 10'd99,   8'hFE, 3'd0, OP_ACK,  10'd0,  1'b1, 1'b1, 32'd99,    4'd2}
  };

  logic        clk, rst_n;
  logic [2:0]  req_cpu;
  logic        rd_en, wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        cand_valid;
  logic [9:0]  cand_id;
  logic [7:0]  cand_prio;
  logic [2:0]  cand_src;
  logic        irq, ack_pulse, eoi_pulse;
  logic [9:0]  ack_id, eoi_id;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  irq_cpu_port #(.CPU_INDEX(CPU), .ACT_DEPTH(4), .ADDR_W(8), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .req_cpu(req_cpu), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cand_valid(cand_valid),
    .cand_id(cand_id), .cand_prio(cand_prio), .cand_src(cand_src), .irq(irq),
    .ack_pulse(ack_pulse), .ack_id(ack_id), .eoi_pulse(eoi_pulse), .eoi_id(eoi_id)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] cpu, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_cpu = cpu; addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] cpu, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_cpu = cpu; addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    string tag;
    req_cpu = 3'(CPU); rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
    cand_valid = 0; cand_id = '0; cand_prio = '0; cand_src = '0;
    do_reset();

    // R1: reset state
    chk("R1", "irq", 32'(irq), 32'd0);
    chk("R1", "ack_pulse", 32'(ack_pulse), 32'd0);
    chk("R1", "eoi_pulse", 32'(eoi_pulse), 32'd0);

    for (int v = 0; v < 20; v++) begin
      tag = $sformatf("R%0d", VECS[v].req);
      bus_wr(3'(CPU), A_CTRL, 32'(VECS[v].en));
      bus_wr(3'(CPU), A_PMASK, 32'(VECS[v].mask));
      cand_valid = VECS[v].cv; cand_id = VECS[v].cid;
      cand_prio = VECS[v].cp; cand_src = VECS[v].cs;
      @(negedge clk);
      chk(tag, $sformatf("vec%0d irq", v), 32'(irq), 32'(VECS[v].xirq));
      if (VECS[v].op == OP_ACK) begin
        bus_rd(3'(CPU), A_ACK, rd);
        chk(tag, $sformatf("vec%0d ack data", v), rd, VECS[v].xrd);
        chk(tag, $sformatf("vec%0d ack pulse", v), 32'(ack_pulse), 32'(VECS[v].xpls));
        if (VECS[v].xpls) chk(tag, $sformatf("vec%0d ack id", v), 32'(ack_id), 32'(VECS[v].cid));
      end else if (VECS[v].op == OP_EOI) begin
        bus_wr(3'(CPU), A_EOI, 32'(VECS[v].wid));
        chk(tag, $sformatf("vec%0d eoi pulse", v), 32'(eoi_pulse), 32'(VECS[v].xpls));
        if (VECS[v].xpls) chk(tag, $sformatf("vec%0d eoi id", v), 32'(eoi_id), 32'(VECS[v].wid));
      end
    end

    // R1: reset mid-run clears registers and the active table (40 was active)
    cand_valid = 1; cand_id = 10'd40; cand_prio = 8'h00; cand_src = 3'd0;
    do_reset();
    chk("R1", "irq after reset", 32'(irq), 32'd0);
    bus_rd(3'(CPU), A_CTRL, rd);  chk("R1", "ctrl after reset", rd, 32'd0);
    bus_rd(3'(CPU), A_PMASK, rd); chk("R1", "pmask after reset", rd, 32'd0);
    bus_wr(3'(CPU), A_CTRL, 32'd1);
    bus_wr(3'(CPU), A_PMASK, 32'hFF);
    @(negedge clk);
    chk("R1", "table empty after reset", 32'(irq), 32'd1);

    // R9: foreign processor number
    bus_rd(3'd1, A_ACK, rd);
    chk("R9", "foreign ack data", rd, 32'd0);
    chk("R9", "foreign ack pulse", 32'(ack_pulse), 32'd0);
    chk("R9", "irq kept after foreign ack", 32'(irq), 32'd1);
    bus_wr(3'd5, A_CTRL, 32'd0);
    @(negedge clk);
    chk("R9", "foreign ctrl write", 32'(irq), 32'd1);
    bus_rd(3'd5, A_CTRL, rd);
    chk("R9", "foreign ctrl read", rd, 32'd0);

    // R10: register readback width and unmapped offset
    bus_wr(3'(CPU), A_PMASK, 32'hFFFF_FAB5);
    bus_rd(3'(CPU), A_PMASK, rd); chk("R10", "pmask readback", rd, 32'h0000_00B5);
    bus_wr(3'(CPU), A_CTRL, 32'hFFFF_FFFF);
    bus_rd(3'(CPU), A_CTRL, rd);  chk("R10", "ctrl readback", rd, 32'd1);
    bus_rd(3'(CPU), 8'h08, rd);   chk("R10", "unmapped read", rd, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule